// File: doc/BRIEF.md
# Staggered Multi-Rank Refresh Scheduler

This block decides when each rank of a multi-rank DRAM channel is due for a refresh. Each rank has its own down-counter, and every counter loses one per clock cycle. At reset the counters take start values spread evenly across one refresh interval, so refresh work is spread out instead of falling due on every rank at once. A round-robin pointer selects the one rank whose counter is examined in a given cycle. When that counter has reached zero, the block emits a one-cycle refresh request naming the rank, reloads that counter for a full interval, and moves the pointer to the next rank, wrapping after the last one.

The block keeps a per-rank "refresh waiting" flag, which tells the command scheduler and the power manager that a rank wants service. The flag is set when a refresh falls due. It is also set early when the pointed-to rank is in power-down and its counter has fallen into the power-up exit window, so the rank can be woken in time. A flag stays set until an acknowledge reports that the refresh command went out to that rank. Issuing the command, tracking bank state and deciding when a rank powers down are left to neighbouring blocks. The power-down status of each rank is an input.

Top module: `rfsh_stagger_sched`

## Requirements
- R1: While reset is high, and in the first cycle after it, `ref_req` is 0 and every bit of `ref_waiting` is 0. Reset loads rank i's counter with (PERIOD_CYC/NUM_RANKS)*(i+1) and points the pointer at rank 0.
- R2: With reset released just after clock edge 0, the first request for rank r appears after edge (r+1)*STEP+1, where STEP = PERIOD_CYC/NUM_RANKS. `ref_rank` then carries r as a binary index.
- R3: `ref_req` is a single-cycle pulse. It is low in the cycle before and the cycle after each request.
- R4: Requests cycle through the ranks in ascending index order and wrap from rank NUM_RANKS-1 to rank 0. A rank's next request follows its previous one by exactly PERIOD_CYC cycles.
- R5: A rank's `ref_waiting` bit becomes 1 in the same cycle as that rank's request and stays 1 until an acknowledge names that rank.
- R6: An acknowledge (`ack_valid`=1 with `ack_rank`=k) clears only bit k of `ref_waiting`, one cycle after it is sampled. The other bits are unaffected.
- R7: When the pointed-to rank has its `rank_pd` bit at 1 and its counter is at or below WAKE_CYC, that rank's `ref_waiting` bit is set one edge later. For rank 0 this happens after edge STEP-WAKE_CYC+1. The request timing does not change.
- R8: A rank whose `rank_pd` bit is 0 gets no early flag. Its `ref_waiting` bit stays 0 until its request.
- R9: If a flag is set by a falling-due or early-wake event in the same cycle as an acknowledge for that rank, the set wins and the bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rank_pd | input | NUM_RANKS | Per-rank powered-down status |
| ack_valid | input | 1 | A refresh command was issued to `ack_rank` |
| ack_rank | input | RW | Rank index of the acknowledge |
| ref_req | output | 1 | One-cycle refresh-due pulse |
| ref_rank | output | RW | Rank index of the current request |
| ref_waiting | output | NUM_RANKS | Per-rank refresh-waiting flags |

## Verification
Every result is registered, so a condition present on the counters before edge n shows at the outputs just after edge n. The first request for rank r is therefore due right after edge (r+1)*STEP+1, and the early wake for rank 0 right after edge STEP-WAKE_CYC+1. An acknowledge driven after edge n takes effect after edge n+1. The bench counts edges from the release of reset and samples on the falling edge of exactly the cycle each result is due. It also samples the cycle before, to catch a result that comes early or late.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    // Start value of a rank's counter: evenly spaced slots over one interval.
    function automatic int unsigned stagger_count(input int unsigned period,
                                                  input int unsigned ranks,
                                                  input int unsigned idx);
        return (period / ranks) * (idx + 1);
    endfunction

    // Index width that can name every rank (at least one bit).
    function automatic int unsigned idx_width(input int unsigned ranks);
        return (ranks > 1) ? $clog2(ranks) : 1;
    endfunction

    // Decision made for the pointed-to rank in one cycle.
    typedef struct packed {
        logic due;    // counter has reached zero
        logic wake;   // powered down and inside the exit window
    } slot_check_t;

endpackage

// File: rtl/rfsh_rank_counter.sv
module rfsh_rank_counter #(
    parameter int unsigned CW        = 9,
    parameter int unsigned INIT_VAL  = 100,
    parameter int unsigned RELOAD_VAL = 399
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reload,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)
            count <= CW'(INIT_VAL);
        else if (reload)
            count <= CW'(RELOAD_VAL);
        else if (count != '0)
            count <= count - 1'b1;
    end
endmodule

// File: rtl/rfsh_rr_ptr.sv
module rfsh_rr_ptr #(
    parameter int unsigned NUM_RANKS = 4,
    parameter int unsigned RW        = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    output logic [RW-1:0] ptr
);
    localparam logic [RW-1:0] LAST = RW'(NUM_RANKS - 1);

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (advance)
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/rfsh_wait_flags.sv
module rfsh_wait_flags #(
    parameter int unsigned NUM_RANKS = 4,
    parameter int unsigned RW        = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_RANKS-1:0] set_vec,
    input  logic                 ack_valid,
    input  logic [RW-1:0]        ack_rank,
    output logic [NUM_RANKS-1:0] waiting
);
    for (genvar i = 0; i < NUM_RANKS; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                waiting[i] <= 1'b0;
            else if (set_vec[i])
                waiting[i] <= 1'b1;          // a new need outranks a clear
            else if (ack_valid && ack_rank == RW'(i))
                waiting[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/rfsh_stagger_sched.sv
module rfsh_stagger_sched #(
    parameter int unsigned NUM_RANKS  = 4,
    parameter int unsigned PERIOD_CYC = 400,
    parameter int unsigned WAKE_CYC   = 6,
    localparam int unsigned RW        = rfsh_pkg::idx_width(NUM_RANKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_RANKS-1:0] rank_pd,
    input  logic                 ack_valid,
    input  logic [RW-1:0]        ack_rank,
    output logic                 ref_req,
    output logic [RW-1:0]        ref_rank,
    output logic [NUM_RANKS-1:0] ref_waiting
);
    localparam int unsigned CW = $clog2(PERIOD_CYC + 1);

    logic [CW-1:0]        cnt [NUM_RANKS];
    logic [RW-1:0]        ptr;
    logic [CW-1:0]        sel_cnt;
    rfsh_pkg::slot_check_t chk;
    logic [NUM_RANKS-1:0] reload_vec;
    logic [NUM_RANKS-1:0] set_vec;

    for (genvar i = 0; i < NUM_RANKS; i++) begin : g_rank
        rfsh_rank_counter #(
            .CW        (CW),
            .INIT_VAL  (rfsh_pkg::stagger_count(PERIOD_CYC, NUM_RANKS, i)),
            .RELOAD_VAL(PERIOD_CYC - 1)
        ) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .reload(reload_vec[i]),
            .count (cnt[i])
        );
        assign reload_vec[i] = (ptr == RW'(i)) && chk.due;
        assign set_vec[i]    = (ptr == RW'(i)) && (chk.due || chk.wake);
    end

    always_comb begin
        sel_cnt  = cnt[ptr];
        chk.due  = (sel_cnt == '0);
        chk.wake = rank_pd[ptr] && (sel_cnt <= CW'(WAKE_CYC));
    end

    rfsh_rr_ptr #(.NUM_RANKS(NUM_RANKS), .RW(RW)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .advance(chk.due),
        .ptr    (ptr)
    );

    rfsh_wait_flags #(.NUM_RANKS(NUM_RANKS), .RW(RW)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .ack_valid(ack_valid),
        .ack_rank (ack_rank),
        .waiting  (ref_waiting)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_req  <= 1'b0;
            ref_rank <= '0;
        end else begin
            ref_req  <= chk.due;
            ref_rank <= chk.due ? ptr : ref_rank;
        end
    end
endmodule

// File: rtl/rfsh_sched_checker.sv
module rfsh_sched_checker #(
    parameter int unsigned NUM_RANKS  = 4,
    parameter int unsigned PERIOD_CYC = 400,
    parameter int unsigned RW         = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_RANKS-1:0] rank_pd,
    input logic                 ack_valid,
    input logic [RW-1:0]        ack_rank,
    input logic                 ref_req,
    input logic [RW-1:0]        ref_rank,
    input logic [NUM_RANKS-1:0] ref_waiting
);
    localparam int unsigned STEP = PERIOD_CYC / NUM_RANKS;
    localparam int unsigned GW   = $clog2(PERIOD_CYC + 2);

    logic          seen;
    logic [RW-1:0] last;
    logic [GW-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= 1'b0;
            last <= '0;
            gap  <= '0;
        end else if (ref_req) begin
            seen <= 1'b1;
            last <= ref_rank;
            gap  <= GW'(1);
        end else if (gap != '1) begin
            gap <= gap + 1'b1;
        end
    end

    assert_pulse_R3: assert property (@(posedge clk) disable iff (rst || STEP < 2)
        ref_req |=> !ref_req);

    assert_order_R4: assert property (@(posedge clk) disable iff (rst)
        (ref_req && seen) |->
        ref_rank == ((last == RW'(NUM_RANKS - 1)) ? '0 : last + 1'b1));

    assert_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        (ref_req && seen && ref_rank != '0) |-> gap == GW'(STEP));

    assert_flag_on_req_R5: assert property (@(posedge clk) disable iff (rst)
        ref_req |-> ref_waiting[ref_rank]);

    for (genvar i = 0; i < NUM_RANKS; i++) begin : g_flag_chk
        assert_clear_needs_ack_R6: assert property (@(posedge clk) disable iff (rst)
            $fell(ref_waiting[i]) |-> ($past(ack_valid) && $past(ack_rank) == RW'(i)));

        assert_rise_cause_R7: assert property (@(posedge clk) disable iff (rst)
            $rose(ref_waiting[i]) |-> ((ref_req && ref_rank == RW'(i)) || $past(rank_pd[i])));
    end
endmodule

bind rfsh_stagger_sched rfsh_sched_checker #(
    .NUM_RANKS (NUM_RANKS),
    .PERIOD_CYC(PERIOD_CYC),
    .RW        (RW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rank_pd    (rank_pd),
    .ack_valid  (ack_valid),
    .ack_rank   (ack_rank),
    .ref_req    (ref_req),
    .ref_rank   (ref_rank),
    .ref_waiting(ref_waiting)
);

// File: tb/tb_rfsh_stagger_sched.sv
module tb_rfsh_stagger_sched;
    localparam int N    = 4;
    localparam int P    = 400;
    localparam int W    = 6;
    localparam int S    = P / N;
    localparam int RW   = 2;
    localparam int HALF = 10;   // 20 ns period, 50 MHz

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  rank_pd = '0;
    logic          ack_valid = 1'b0;
    logic [RW-1:0] ack_rank = '0;
    logic          ref_req;
    logic [RW-1:0] ref_rank;
    logic [N-1:0]  ref_waiting;

    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;

    rfsh_stagger_sched #(.NUM_RANKS(N), .PERIOD_CYC(P), .WAKE_CYC(W)) dut (
        .clk(clk), .rst(rst), .rank_pd(rank_pd), .ack_valid(ack_valid),
        .ack_rank(ack_rank), .ref_req(ref_req), .ref_rank(ref_rank),
        .ref_waiting(ref_waiting)
    );

    always #HALF clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s at edge %0d: actual=%0d expected=%0d", req, what, cyc, act, exp);
        end
    endtask

    // Reset, then release after a falling edge; edge 1 is the next rising edge.
    task automatic do_reset();
        rst = 1'b1;
        ack_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic at_edge(input int n);
        while (cyc != n) @(negedge clk);
    endtask

    task automatic pulse_ack(input int rank);
        ack_valid = 1'b1;
        ack_rank  = RW'(rank);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", "req in reset", ref_req, 0);
        check("R1", "waiting in reset", ref_waiting, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "req after release", ref_req, 0);
        check("R1", "waiting after release", ref_waiting, 0);
    endtask

    task automatic t_order();
        rank_pd = '0;
        do_reset();
        at_edge(S);
        check("R3", "req before rank0", ref_req, 0);
        check("R8", "no early flag without pd", ref_waiting, 0);
        for (int r = 0; r < N; r++) begin
            at_edge((r + 1) * S + 1);
            check("R2", "req for rank", ref_req, 1);
            check("R2", "rank index", ref_rank, r);
            check("R5", "flag set with req", ref_waiting[r], 1);
            at_edge((r + 1) * S + 2);
            check("R3", "req after pulse", ref_req, 0);
        end
        at_edge(S + P);
        check("R4", "no early repeat", ref_req, 0);
        check("R5", "flags held without ack", ref_waiting, 4'hF);
        at_edge(S + P + 1);
        check("R4", "wrap req", ref_req, 1);
        check("R4", "wrap to rank0", ref_rank, 0);
    endtask

    task automatic t_ack();
        rank_pd = '0;
        do_reset();
        at_edge(4 * S + 2);
        pulse_ack(1);
        check("R6", "only rank1 cleared", ref_waiting, 4'b1101);
        at_edge(4 * S + 6);
        check("R6", "flags stable after ack", ref_waiting, 4'b1101);
        at_edge(S + P);
        pulse_ack(0);          // sampled at the edge where rank0 falls due again
        check("R9", "req on collision", ref_req, 1);
        check("R9", "set wins over ack", ref_waiting[0], 1);
        pulse_ack(0);
        check("R6", "rank0 cleared", ref_waiting, 4'b1100);
    endtask

    task automatic t_early();
        rank_pd = 4'b0001;
        do_reset();
        at_edge(S - W);
        check("R7", "no flag before window", ref_waiting[0], 0);
        at_edge(S - W + 1);
        check("R7", "early wake flag", ref_waiting[0], 1);
        check("R7", "no req yet", ref_req, 0);
        check("R8", "other ranks quiet", ref_waiting[3:1], 0);
        at_edge(S);
        check("R7", "req not early", ref_req, 0);
        at_edge(S + 1);
        check("R7", "req on time", ref_req, 1);
        check("R7", "req rank", ref_rank, 0);
        rank_pd = '0;
    endtask

    initial begin
        t_reset_state();
        t_order();
        t_ack();
        t_early();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(2 * HALF * 200000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule